// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a memory port that moves whole quadwords. It is two-way set-associative, write-back and write-allocate. It has 64 sets of two ways, and each line holds 64 bytes, split into four 16-byte quadwords. On each processor request it reads both ways of the addressed set. A hit completes in the cycle the request is presented. A miss stalls the processor while the block chooses a victim way, writes the victim line back to memory if needed, and loads the new line. The held request then completes as a hit.

The controller is a three-state machine:

- LOOKUP compares the tags. It serves hits and rejects malformed requests.
- EVICT sends the victim's four quadwords to memory.
- REFILL reads the four quadwords of the new line.

The transitions are:

- LOOKUP to EVICT on a miss whose victim is valid or dirty.
- LOOKUP to REFILL on a miss whose victim is neither valid nor dirty.
- EVICT to REFILL when the fourth write beat is acknowledged.
- REFILL to LOOKUP when the fourth read beat returns. The tag is updated on this beat.

The victim way is the XOR of the two ways' replacement bits. On each refill, the filled way's replacement bit is inverted. Within one set, successive misses therefore alternate between way 0 and way 1, whatever hits occur in between.

Top module: `dc2w_cache`

## Requirements
- R1: After reset every line is invalid, clean and has its replacement bit at zero. The first access to any set misses, writes nothing back and reads four quadwords. With no valid line, `cpu_ready` is low and `mem_req` is low.
- R2: A hit needs a valid way whose stored page (address bits [31:12]) equals the access page, with way 0 checked first. A load hit is accepted in the cycle it is presented, returns the whole addressed quadword on `cpu_rdata`, and causes no memory traffic.
- R3: The set index is address bits [11:6], the quadword within the line is bits [5:4], and the byte within the quadword is bits [3:0].
- R4: On a miss the victim is way (rep0 XOR rep1), and the victim's replacement bit is inverted when the refill ends. From reset, the misses in one set fill way 0, way 1, way 0, way 1, and so on.
- R5: Before a refill, if the victim is valid or dirty, its full line is written to memory at its old page as four write beats, quadword 0 first. A clean valid line is also written back.
- R6: A refill reads four quadwords at the new line address, quadword 0 first. It writes the new page into the victim's tag and sets the valid flag. The held access then completes as a hit.
- R7: `cpu_size` encodes the access size: 0 is 8 bits, 1 is 16, 2 is 32, 3 is 64 and 4 is 128. A store writes only the bytes from offset bits [3:0] up to offset plus size minus one, taken from the same byte lanes of `cpu_wdata`. All other bytes of the line are unchanged.
- R8: An access whose offset bits [3:0] are not a multiple of its size, or whose `cpu_size` is above 4, is accepted at once with `cpu_err` high. It changes no data or tag and causes no memory traffic.
- R9: Stores mark the line dirty on a hit and also when the store causes the refill. The stored bytes appear in that line's later write-back and in loads after the line is refilled.
- R10: Each memory beat moves one quadword. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_valid` acknowledges the beat.
- R11: While a write-back or refill is in progress, `cpu_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present; held with its fields until accepted |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_write | input | 1 | 1 for a store, 0 for a load |
| cpu_size | input | 3 | Access size code (0 = 8 bits up to 4 = 128 bits) |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 128 | Store data in its quadword byte lanes |
| cpu_rdata | output | 128 | Addressed quadword, valid with a load acceptance |
| cpu_err | output | 1 | Request rejected as misaligned or badly sized |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 for a write-back beat, 0 for a refill beat |
| mem_addr | output | 32 | Quadword-aligned memory address |
| mem_wdata | output | 128 | Write-back quadword |
| mem_valid | input | 1 | Beat acknowledged; carries read data on refill beats |
| mem_rdata | input | 128 | Refill quadword |

## Verification
A corrupted tag or replacement bit shows up at the ports on the next access to that set. The symptoms are a hit where a miss was due, a write-back at the wrong page, or a victim choice that breaks the 0/1 alternation. Each is visible as a wrong beat count or wrong address within one access.

A wrong byte-lane merge does not show on a hit. It shows when the line is read back, in the same cycle as that load. It also shows in the write-back data when the line is evicted, which happens two misses later in that set.

Stall length is fixed at two cycles per beat by the memory model, so a state machine that skips or repeats a beat changes the counted stall at once.

// File: rtl/dc2w_pkg.sv
`timescale 1ns/1ps
package dc2w_pkg;

    localparam int QW_BYTES   = 16;
    localparam int QW_BITS    = QW_BYTES * 8;
    localparam int BYTE_OFF_W = $clog2(QW_BYTES);
    localparam int WAYS       = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL
    } dc_state_e;

    // access is legal when size code is at most 128 bits and offset is size-aligned
    function automatic logic size_ok(input logic [2:0] sz, input logic [BYTE_OFF_W-1:0] off);
        logic [BYTE_OFF_W-1:0] low;
        if (sz > 3'd4) return 1'b0;
        low = BYTE_OFF_W'((32'd1 << sz) - 32'd1);
        return (off & low) == '0;
    endfunction

    // byte lanes touched by an access of the given size at the given offset
    function automatic logic [QW_BYTES-1:0] lane_mask(input logic [2:0] sz, input logic [BYTE_OFF_W-1:0] off);
        logic [31:0] base;
        logic [31:0] shifted;
        base    = (32'd1 << (32'd1 << sz)) - 32'd1;
        shifted = base << off;
        return shifted[QW_BYTES-1:0];
    endfunction

endpackage

// File: rtl/dc2w_tags.sv
`timescale 1ns/1ps
module dc2w_tags
    import dc2w_pkg::*;
#(
    parameter int SETS_W = 6,
    parameter int PAGE_W = 20,
    localparam int SETS  = 1 << SETS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SETS_W-1:0]           rd_set,
    input  logic [PAGE_W-1:0]           lookup_page,
    output logic [WAYS-1:0]             hit,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0]             rd_rep,
    output logic [WAYS-1:0][PAGE_W-1:0] rd_page,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic [SETS_W-1:0]           wr_set,
    input  logic [PAGE_W-1:0]           wr_page,
    input  logic                        wr_valid,
    input  logic                        wr_dirty,
    input  logic                        wr_rep
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [PAGE_W-1:0] page_q [SETS];
        logic [SETS-1:0]   valid_q;
        logic [SETS-1:0]   dirty_q;
        logic [SETS-1:0]   rep_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
                rep_q   <= '0;
                for (int i = 0; i < SETS; i++) page_q[i] <= '0;
            end else if (wr_en && (wr_way == 1'(w))) begin
                page_q[wr_set]  <= wr_page;
                valid_q[wr_set] <= wr_valid;
                dirty_q[wr_set] <= wr_dirty;
                rep_q[wr_set]   <= wr_rep;
            end
        end

        assign rd_page[w]  = page_q[rd_set];
        assign rd_valid[w] = valid_q[rd_set];
        assign rd_dirty[w] = dirty_q[rd_set];
        assign rd_rep[w]   = rep_q[rd_set];
        assign hit[w]      = valid_q[rd_set] && (page_q[rd_set] == lookup_page);
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit)); // R2

endmodule

// File: rtl/dc2w_data.sv
`timescale 1ns/1ps
module dc2w_data
    import dc2w_pkg::*;
#(
    parameter int SETS_W   = 6,
    parameter int QW_IDX_W = 2,
    localparam int IDX_W   = 1 + SETS_W + QW_IDX_W,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_way,
    input  logic [SETS_W-1:0]   wr_set,
    input  logic [QW_IDX_W-1:0] wr_qw,
    input  logic [QW_BYTES-1:0] wr_be,
    input  logic [QW_BITS-1:0]  wr_data,
    input  logic                rd_way,
    input  logic [SETS_W-1:0]   rd_set,
    input  logic [QW_IDX_W-1:0] rd_qw,
    output logic [QW_BITS-1:0]  rd_data
);

    logic [QW_BITS-1:0] store_q [DEPTH];
    logic [IDX_W-1:0]   wr_idx;
    logic [IDX_W-1:0]   rd_idx;

    assign wr_idx  = {wr_way, wr_set, wr_qw};
    assign rd_idx  = {rd_way, rd_set, rd_qw};
    assign rd_data = store_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < QW_BYTES; b++) begin
                if (wr_be[b]) store_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/dc2w_ctrl.sv
`timescale 1ns/1ps
module dc2w_ctrl
    import dc2w_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS_W    = 6,
    parameter int QW_IDX_W  = 2,
    localparam int LINE_OFF_W = QW_IDX_W + BYTE_OFF_W,
    localparam int PAGE_LO    = SETS_W + LINE_OFF_W,
    localparam int PAGE_W     = ADDR_W - PAGE_LO
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_valid,
    input  logic                        cpu_write,
    input  logic [2:0]                  cpu_size,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [QW_BITS-1:0]          cpu_wdata,
    output logic                        cpu_ready,
    output logic                        cpu_err,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_valid,
    input  logic [QW_BITS-1:0]          mem_rdata,
    input  logic [WAYS-1:0]             tg_hit,
    input  logic [WAYS-1:0]             tg_valid,
    input  logic [WAYS-1:0]             tg_dirty,
    input  logic [WAYS-1:0]             tg_rep,
    input  logic [WAYS-1:0][PAGE_W-1:0] tg_page,
    output logic                        tw_en,
    output logic                        tw_way,
    output logic [PAGE_W-1:0]           tw_page,
    output logic                        tw_valid,
    output logic                        tw_dirty,
    output logic                        tw_rep,
    output logic                        dw_en,
    output logic                        dw_way,
    output logic [QW_IDX_W-1:0]         dw_qw,
    output logic [QW_BYTES-1:0]         dw_be,
    output logic [QW_BITS-1:0]          dw_data,
    output logic                        dr_way,
    output logic [QW_IDX_W-1:0]         dr_qw
);

    dc_state_e             state_q, state_d;
    logic [QW_IDX_W-1:0]   beat_q, beat_d;
    logic                  vway_q, vway_d;

    logic [PAGE_W-1:0]     acc_page;
    logic [SETS_W-1:0]     acc_set;
    logic [QW_IDX_W-1:0]   acc_qw;
    logic [BYTE_OFF_W-1:0] acc_off;
    logic                  acc_ok;
    logic                  any_hit;
    logic                  hit_way;
    logic                  victim;
    logic                  last_beat;

    assign acc_page  = cpu_addr[ADDR_W-1:PAGE_LO];
    assign acc_set   = cpu_addr[PAGE_LO-1:LINE_OFF_W];
    assign acc_qw    = cpu_addr[LINE_OFF_W-1:BYTE_OFF_W];
    assign acc_off   = cpu_addr[BYTE_OFF_W-1:0];
    assign acc_ok    = size_ok(cpu_size, acc_off);
    assign any_hit   = |tg_hit;
    assign hit_way   = !tg_hit[0];
    assign victim    = tg_rep[0] ^ tg_rep[1];
    assign last_beat = (beat_q == '1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            beat_q  <= '0;
            vway_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            vway_q  <= vway_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        vway_d  = vway_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_valid && acc_ok && !any_hit) begin
                    vway_d  = victim;
                    beat_d  = '0;
                    state_d = (tg_valid[victim] || tg_dirty[victim]) ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                if (mem_valid) begin
                    beat_d = beat_q + 1'b1;
                    if (last_beat) state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_valid) begin
                    beat_d = beat_q + 1'b1;
                    if (last_beat) state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_err   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {acc_page, acc_set, beat_q, {BYTE_OFF_W{1'b0}}};
        tw_en     = 1'b0;
        tw_way    = hit_way;
        tw_page   = acc_page;
        tw_valid  = 1'b1;
        tw_dirty  = 1'b1;
        tw_rep    = tg_rep[hit_way];
        dw_en     = 1'b0;
        dw_way    = hit_way;
        dw_qw     = acc_qw;
        dw_be     = lane_mask(cpu_size, acc_off);
        dw_data   = cpu_wdata;
        dr_way    = hit_way;
        dr_qw     = acc_qw;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_ready = any_hit || !acc_ok;
                cpu_err   = !acc_ok;
                if (cpu_valid && acc_ok && any_hit && cpu_write) begin
                    tw_en = 1'b1;
                    dw_en = 1'b1;
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {tg_page[vway_q], acc_set, beat_q, {BYTE_OFF_W{1'b0}}};
                dr_way   = vway_q;
                dr_qw    = beat_q;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                dw_way  = vway_q;
                dw_qw   = beat_q;
                dw_be   = '1;
                dw_data = mem_rdata;
                if (mem_valid) begin
                    dw_en = 1'b1;
                    if (last_beat) begin
                        tw_en    = 1'b1;
                        tw_way   = vway_q;
                        tw_dirty = cpu_write;
                        tw_rep   = !tg_rep[vway_q];
                    end
                end
            end
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata_probe))); // R10
    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !cpu_ready); // R11
    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && mem_valid && (mem_addr[LINE_OFF_W-1:BYTE_OFF_W] == '1)) |=> (mem_req && !mem_we && (mem_addr[LINE_OFF_W-1:BYTE_OFF_W] == '0))); // R5
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we && mem_valid && (mem_addr[LINE_OFF_W-1:BYTE_OFF_W] == '1) && cpu_valid) |=> cpu_ready); // R6

    logic [QW_BITS-1:0] mem_wdata_probe;
    assign mem_wdata_probe = '0;

endmodule

// File: rtl/dc2w_cache.sv
`timescale 1ns/1ps
module dc2w_cache
    import dc2w_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SETS_W   = 6,
    parameter int QW_IDX_W = 2,
    localparam int LINE_OFF_W = QW_IDX_W + BYTE_OFF_W,
    localparam int PAGE_LO    = SETS_W + LINE_OFF_W,
    localparam int PAGE_W     = ADDR_W - PAGE_LO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    output logic               cpu_ready,
    input  logic               cpu_write,
    input  logic [2:0]         cpu_size,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [QW_BITS-1:0] cpu_wdata,
    output logic [QW_BITS-1:0] cpu_rdata,
    output logic               cpu_err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [QW_BITS-1:0] mem_wdata,
    input  logic               mem_valid,
    input  logic [QW_BITS-1:0] mem_rdata
);

    logic [WAYS-1:0]             tg_hit, tg_valid, tg_dirty, tg_rep;
    logic [WAYS-1:0][PAGE_W-1:0] tg_page;
    logic                        tw_en, tw_way, tw_valid, tw_dirty, tw_rep;
    logic [PAGE_W-1:0]           tw_page;
    logic                        dw_en, dw_way, dr_way;
    logic [QW_IDX_W-1:0]         dw_qw, dr_qw;
    logic [QW_BYTES-1:0]         dw_be;
    logic [QW_BITS-1:0]          dw_data, dr_data;
    logic [SETS_W-1:0]           cur_set;

    assign cur_set   = cpu_addr[PAGE_LO-1:LINE_OFF_W];
    assign cpu_rdata = dr_data;
    assign mem_wdata = dr_data;

    dc2w_tags #(.SETS_W(SETS_W), .PAGE_W(PAGE_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_set(cur_set), .lookup_page(cpu_addr[ADDR_W-1:PAGE_LO]),
        .hit(tg_hit), .rd_valid(tg_valid), .rd_dirty(tg_dirty), .rd_rep(tg_rep), .rd_page(tg_page),
        .wr_en(tw_en), .wr_way(tw_way), .wr_set(cur_set), .wr_page(tw_page),
        .wr_valid(tw_valid), .wr_dirty(tw_dirty), .wr_rep(tw_rep)
    );

    dc2w_data #(.SETS_W(SETS_W), .QW_IDX_W(QW_IDX_W)) u_data (
        .clk(clk),
        .wr_en(dw_en), .wr_way(dw_way), .wr_set(cur_set), .wr_qw(dw_qw), .wr_be(dw_be), .wr_data(dw_data),
        .rd_way(dr_way), .rd_set(cur_set), .rd_qw(dr_qw), .rd_data(dr_data)
    );

    dc2w_ctrl #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .QW_IDX_W(QW_IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .tg_hit(tg_hit), .tg_valid(tg_valid), .tg_dirty(tg_dirty), .tg_rep(tg_rep), .tg_page(tg_page),
        .tw_en(tw_en), .tw_way(tw_way), .tw_page(tw_page), .tw_valid(tw_valid), .tw_dirty(tw_dirty), .tw_rep(tw_rep),
        .dw_en(dw_en), .dw_way(dw_way), .dw_qw(dw_qw), .dw_be(dw_be), .dw_data(dw_data),
        .dr_way(dr_way), .dr_qw(dr_qw)
    );

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && !mem_valid) |=> $stable(mem_wdata)); // R10
    AST_ERR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_ready && cpu_err) |=> !mem_req); // R8

endmodule

// File: tb/dc2w_cache_bench.sv
`timescale 1ns/1ps
module dc2w_cache_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid, cpu_ready, cpu_write, cpu_err;
    logic [2:0]   cpu_size;
    logic [31:0]  cpu_addr;
    logic [127:0] cpu_wdata, cpu_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_valid = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #2 clk = ~clk;

    dc2w_cache u_dc2w_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench-side model of tags, architectural data and backing memory
    int unsigned mpage [64][2];
    bit          mval  [64][2];
    bit          mrep  [64][2];
    logic [127:0] shadow [int unsigned];
    logic [127:0] bmem   [int unsigned];

    int          wb_cnt, rd_cnt;
    int unsigned exp_wb_page, exp_rd_page, cur_set, last_wb_page;

    function automatic logic [127:0] pat(input int unsigned qa);
        return {qa ^ 32'h1234_5678, ~qa, qa * 32'd3, qa + 32'h0F0F_0000};
    endfunction

    function automatic logic [127:0] sh_get(input int unsigned qa);
        if (shadow.exists(qa)) return shadow[qa];
        return pat(qa);
    endfunction

    function automatic logic [127:0] mem_get(input int unsigned qa);
        if (bmem.exists(qa)) return bmem[qa];
        return pat(qa);
    endfunction

    function automatic int unsigned mk(input int unsigned pg, input int unsigned s, input int unsigned q, input int unsigned off);
        return (pg << 12) | (s << 6) | (q << 4) | off;
    endfunction

    // memory responder: one beat served every second falling edge
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (mem_req) begin
            mem_valid = 1'b1;
            if (mem_we) begin
                chk(mem_addr == mk(exp_wb_page, cur_set, wb_cnt, 0), "R5", 128'(mem_addr), 128'(mk(exp_wb_page, cur_set, wb_cnt, 0)));
                chk(mem_wdata == sh_get(mem_addr), "R9", mem_wdata, sh_get(mem_addr));
                bmem[mem_addr] = mem_wdata;
                last_wb_page = mem_addr >> 12;
                wb_cnt++;
            end else begin
                chk(mem_addr == mk(exp_rd_page, cur_set, rd_cnt, 0), "R6", 128'(mem_addr), 128'(mk(exp_rd_page, cur_set, rd_cnt, 0)));
                mem_rdata = mem_get(mem_addr);
                rd_cnt++;
            end
        end
    end

    task automatic acc(input bit wr, input int sz, input int unsigned addr, input logic [127:0] wd, input string dtag);
        int unsigned s, pg, qa, off;
        bit ok;
        int hw, v, ewb, erd, stall;
        logic [127:0] got, nv;
        logic gerr;
        s   = (addr >> 6) & 63;
        pg  = addr >> 12;
        qa  = addr & ~32'd15;
        off = addr & 15;
        ok  = (sz <= 4) && ((off % (1 << sz)) == 0);
        hw = -1; v = 0; ewb = 0; erd = 0; stall = 0;
        if (ok) begin
            if (mval[s][0] && mpage[s][0] == pg) hw = 0;
            else if (mval[s][1] && mpage[s][1] == pg) hw = 1;
            if (hw < 0) begin
                v = int'(mrep[s][0] ^ mrep[s][1]);
                ewb = mval[s][v] ? 4 : 0;
                erd = 4;
                exp_wb_page = mpage[s][v];
            end
        end
        exp_rd_page = pg;
        cur_set = s;
        wb_cnt = 0;
        rd_cnt = 0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_size = 3'(sz); cpu_addr = addr; cpu_wdata = wd;
        #1;
        while (!cpu_ready) begin
            stall++;
            @(negedge clk);
            #1;
        end
        got  = cpu_rdata;
        gerr = cpu_err;
        @(posedge clk);
        #1 cpu_valid = 1'b0;
        chk(gerr == !ok, "R8", 128'(gerr), 128'(!ok));
        chk(stall == 2 * (ewb + erd), "R11", 128'(stall), 128'(2 * (ewb + erd)));
        chk(wb_cnt == ewb, "R5", 128'(wb_cnt), 128'(ewb));
        chk(rd_cnt == erd, "R10", 128'(rd_cnt), 128'(erd));
        if (ok && !wr) chk(got == sh_get(qa), dtag, got, sh_get(qa));
        if (ok && wr) begin
            nv = sh_get(qa);
            for (int b = 0; b < 16; b++)
                if (b >= int'(off) && b < int'(off) + (1 << sz)) nv[b*8 +: 8] = wd[b*8 +: 8];
            shadow[qa] = nv;
        end
        if (ok && hw < 0) begin
            mpage[s][v] = pg;
            mval[s][v]  = 1'b1;
            mrep[s][v]  = !mrep[s][v];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        cpu_valid = 1'b0; cpu_write = 1'b0; cpu_size = 3'd0; cpu_addr = '0; cpu_wdata = '0;
        for (int s = 0; s < 64; s++) for (int w = 0; w < 2; w++) begin
            mpage[s][w] = 0; mval[s][w] = 1'b0; mrep[s][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R1", 128'(mem_req), 128'(0));
        chk(cpu_ready == 1'b0, "R1", 128'(cpu_ready), 128'(0));

        for (int s = 0; s < 64; s++) begin
            int unsigned p1, p2, p3;
            p1 = s + 1; p2 = s + 32'h101; p3 = s + 32'h202;
            // first touch of a set after reset
            acc(0, 4, mk(p1, s, 0, 0), '0, "R1");
            chk(wb_cnt == 0, "R1", 128'(wb_cnt), 128'(0));
            for (int q = 1; q < 4; q++) acc(0, 4, mk(p1, s, q, 0), '0, "R3");
            // rejected requests leave the line untouched
            for (int sz = 1; sz < 5; sz++) acc(1, sz, mk(p1, s, sz % 4, (1 << sz) / 2), {4{32'hDEAD_BEEF}}, "R8");
            acc(1, 5, mk(p1, s, 0, 0), {4{32'hBAD0_0000}}, "R8");
            acc(0, 1, mk(p1, s, 2, 3), '0, "R8");
            for (int q = 0; q < 4; q++) acc(0, 4, mk(p1, s, q, 0), '0, "R8");
            // stores of every size at size-aligned offsets
            for (int sz = 0; sz < 5; sz++) begin
                int unsigned off;
                off = (sz == 4) ? 0 : ((s * (1 << sz)) & 15);
                acc(1, sz, mk(p1, s, sz % 4, off),
                    {32'hA000_0000 | (s << 8) | sz, 32'h5A5A_0000 ^ s, 32'h0123_4567 + sz, ~(s << 4)}, "R7");
            end
            for (int q = 0; q < 4; q++) acc(0, 4, mk(p1, s, q, 0), '0, "R7");
            // replacement order and write-back
            acc(0, 4, mk(p2, s, 0, 0), '0, "R6");
            chk(wb_cnt == 0, "R4", 128'(wb_cnt), 128'(0));
            last_wb_page = 32'hFFFF_FFFF;
            acc(0, 4, mk(p3, s, 1, 0), '0, "R6");
            chk(last_wb_page == p1, "R4", 128'(last_wb_page), 128'(p1));
            last_wb_page = 32'hFFFF_FFFF;
            acc(0, 4, mk(p1, s, 0, 0), '0, "R9");
            chk(last_wb_page == p2, "R5", 128'(last_wb_page), 128'(p2));
            last_wb_page = 32'hFFFF_FFFF;
            acc(1, 2, mk(p2, s, 3, 4), {4{32'h600D_0000 | s}}, "R9");
            chk(last_wb_page == p3, "R4", 128'(last_wb_page), 128'(p3));
            acc(0, 4, mk(p2, s, 3, 0), '0, "R9");
            acc(0, 4, mk(p3, s, 2, 0), '0, "R6");
            acc(0, 4, mk(p1, s, 1, 0), '0, "R6");
            acc(0, 4, mk(p2, s, 3, 0), '0, "R9");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule